// File: doc/BRIEF.md
# Tone Detect Guard-Time Qualifier

This block turns a raw early-detect flag from a dual-tone alert detector into a steering output that has been qualified by guard times. The raw flag is high while both tones of the alert pair are present. The raw flag is low once the detector stops seeing them.

The qualified output goes high only after the raw flag has stayed high for a programmable tone-present guard time, so short detections are rejected. After the output is high, it stays high through dropouts of the raw flag that are shorter than a separate tone-absent guard time. The two durations are given in milliseconds and are counted on a one-millisecond tick, which gives asymmetric hysteresis.

An enable input works as an on/off switch for the detector. With the enable off, the output is forced low and raw activity has no effect. A guard-busy output shows when a guard interval is being timed. In a typical setup, the present time is chosen so that the total recognition time reaches at least 20 ms. An absent time of 15 ms gives a total absence time of 15 to 25 ms.

Top module: `tone_guard_qual`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, `qual_det` and `guard_busy` are 0.
- R2: With `det_en`=1 and `qual_det`=0, `qual_det` becomes 1 at the clock edge of the (P+1)-th `ms_tick` pulse counted while `raw_det` has stayed 1, where P is `present_ms`.
- R3: A high period of `raw_det` that contains P or fewer tick pulses leaves `qual_det` at 0. The count restarts at zero, so a later high period again needs P+1 ticks.
- R4: With `qual_det`=1, `qual_det` becomes 0 at the edge of the (A+1)-th tick pulse counted while `raw_det` has stayed 0, where A is `absent_ms`.
- R5: A dropout of `raw_det` that contains A or fewer tick pulses leaves `qual_det` at 1. The count restarts, so a later dropout again needs A+1 ticks.
- R6: A programmed duration of 0 makes `qual_det` take the value of `raw_det` at the edge of the next tick pulse.
- R7: When `det_en`=0 at a clock edge, `qual_det` is 0 after that edge, and `raw_det` does not affect it. When the enable returns, counting starts afresh.
- R8: `guard_busy` equals `det_en` AND (`raw_det` XOR `qual_det`), combinationally, when input synchronization is off (the default).
- R9: While `det_en`=1, `qual_det` changes only at clock edges where `ms_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| raw_det | input | 1 | Raw dual-tone early-detect flag |
| det_en | input | 1 | Detector enable; 0 forces the output low |
| present_ms | input | CNT_W | Tone-present guard time in ms |
| absent_ms | input | CNT_W | Tone-absent guard time in ms |
| qual_det | output | 1 | Guard-time-qualified detect flag |
| guard_busy | output | 1 | A guard interval is being timed |

## Verification
The guard expiry and a change of the raw flag can arrive at the same clock edge. In that case the tick that would complete the count falls in the same cycle in which the raw flag returns to agree with the output. The bench drives exactly P and A tick pulses before reverting, and also one pulse more. The output must then flip only in the P+1 (or A+1) case. The enable dropping in the same cycle as an expiring tick is also driven, and the output must stay low.

// File: rtl/tg_pkg.sv
package tg_pkg;
   localparam int TG_MAX_W = 16;

   // which guard interval applies, chosen by the current output level
   typedef enum logic {
      TG_WAIT_ON  = 1'b0,
      TG_WAIT_OFF = 1'b1
   } tg_side_e;
endpackage

// File: rtl/tg_input_stage.sv
module tg_input_stage #(
   parameter int IN_SYNC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (IN_SYNC != 0) begin : g_sync
         logic [1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[0], d};
         end
         assign q = sh[1];
      end else begin : g_pass
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/tg_guard_timer.sv
module tg_guard_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic         expire
);
   logic [W-1:0] cnt;

   assign expire = run & tick & (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!run || expire)   cnt <= '0;
      else if (tick)             cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tg_steer_reg.sv
module tg_steer_reg
   import tg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  logic     flip,
   output tg_side_e side,
   output logic     q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (!en)   q <= 1'b0;
      else if (flip)  q <= ~q;
   end

   assign side = q ? TG_WAIT_OFF : TG_WAIT_ON;
endmodule

// File: rtl/tone_guard_qual.sv
module tone_guard_qual
   import tg_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int IN_SYNC = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic             raw_det,
   input  logic             det_en,
   input  logic [CNT_W-1:0] present_ms,
   input  logic [CNT_W-1:0] absent_ms,
   output logic             qual_det,
   output logic             guard_busy
);
   generate
      if (CNT_W < 1 || CNT_W > TG_MAX_W) begin : g_bad_w
         $error("tone_guard_qual: CNT_W out of range");
      end
      if (IN_SYNC != 0 && IN_SYNC != 1) begin : g_bad_sync
         $error("tone_guard_qual: IN_SYNC must be 0 or 1");
      end
   endgenerate

   logic             raw_s;
   logic             mismatch;
   logic             expire;
   tg_side_e         side;
   logic [CNT_W-1:0] limit;

   tg_input_stage #(.IN_SYNC(IN_SYNC)) u_in (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_det),
      .q     (raw_s)
   );

   assign mismatch = det_en & (raw_s ^ qual_det);
   assign limit    = (side == TG_WAIT_OFF) ? absent_ms : present_ms;

   tg_guard_timer #(.W(CNT_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (mismatch),
      .tick   (ms_tick),
      .limit  (limit),
      .expire (expire)
   );

   tg_steer_reg u_st (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (det_en),
      .flip  (expire),
      .side  (side),
      .q     (qual_det)
   );

   assign guard_busy = mismatch;
endmodule

// File: rtl/tg_guard_chk.sv
module tg_guard_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         ms_tick,
   input logic         raw_det,
   input logic         det_en,
   input logic [W-1:0] present_ms,
   input logic [W-1:0] absent_ms,
   input logic         qual_det,
   input logic         guard_busy
);
   logic unused_raw;
   assign unused_raw = raw_det;

   assert_en_off_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !det_en |=> !qual_det);

   assert_rise_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(qual_det) |-> $past(det_en));

   assert_busy_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !det_en |-> !guard_busy);

   assert_change_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(det_en) && (qual_det != $past(qual_det))) |-> $past(ms_tick));

   assert_zero_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_busy && ms_tick && !qual_det && present_ms == '0) |=> qual_det);

   assert_zero_absent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_busy && ms_tick && qual_det && absent_ms == '0) |=> !qual_det);

   assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (det_en && !guard_busy) |=> $stable(qual_det));
endmodule

bind tone_guard_qual tg_guard_chk #(.W(CNT_W)) u_chk (.*);

// File: tb/sim_tone_guard_qual.sv
module sim_tone_guard_qual;
   localparam int W = 8;

   typedef struct {
      logic  q;
      logic  busy;
      string tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ms_tick = 1'b0;
   logic         raw_det = 1'b0;
   logic         det_en = 1'b0;
   logic [W-1:0] present_ms = 8'd3;
   logic [W-1:0] absent_ms = 8'd2;
   logic         qual_det;
   logic         guard_busy;

   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   // expectation state derived from the requirements
   logic m_q = 1'b0;
   int   m_run = 0;

   always #10 clk = ~clk;

   tone_guard_qual #(.CNT_W(W)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .ms_tick    (ms_tick),
      .raw_det    (raw_det),
      .det_en     (det_en),
      .present_ms (present_ms),
      .absent_ms  (absent_ms),
      .qual_det   (qual_det),
      .guard_busy (guard_busy)
   );

   // one cycle: drive at negedge, push what must be seen after the next posedge
   task automatic cyc(input logic r, input logic en, input logic tk, input string tag);
      exp_t e;
      int need;
      @(negedge clk);
      raw_det = r;
      det_en  = en;
      ms_tick = tk;
      if (!en) begin
         m_q = 1'b0; m_run = 0;
      end else if (r == m_q) begin
         m_run = 0;
      end else if (tk) begin
         m_run++;
         need = (m_q ? int'(absent_ms) : int'(present_ms)) + 1;
         if (m_run == need) begin
            m_q = r; m_run = 0;
         end
      end
      e.q = m_q;
      e.busy = en && (r != m_q);
      e.tag = tag;
      sb.push_back(e);
   endtask

   // n tick pulses, each followed by one idle cycle
   task automatic ticks(input logic r, input logic en, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         cyc(r, en, 1'b1, tag);
         cyc(r, en, 1'b0, tag);
      end
   endtask

   task automatic point(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
      end
   endtask

   // monitor: compare after every edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            point({e.tag, " qual_det"}, qual_det, e.q);
            point("R8 guard_busy", guard_busy, e.busy);
         end
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      point("R1 qual in reset", qual_det, 1'b0);
      point("R1 busy in reset", guard_busy, 1'b0);
      rst_n = 1'b1;
      cyc(1'b0, 1'b1, 1'b0, "R1");
      ticks(1'b0, 1'b1, 2, "R1");

      // R2: P=3 -> rises on 4th tick
      ticks(1'b1, 1'b1, 3, "R2");
      @(negedge clk); point("R2 low after P ticks", qual_det, 1'b0);
      ticks(1'b1, 1'b1, 3, "R2");
      // R9: long gaps without ticks keep the output still
      for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b0, "R9");
      cyc(1'b1, 1'b1, 1'b0, "R9");
      // R5: dropout of exactly A=2 ticks masked, twice
      ticks(1'b0, 1'b1, 2, "R5");
      ticks(1'b1, 1'b1, 1, "R5");
      ticks(1'b0, 1'b1, 2, "R5");
      ticks(1'b1, 1'b1, 1, "R5");
      @(negedge clk); point("R5 still high", qual_det, 1'b1);
      // R4: A+1 ticks low drops the output
      ticks(1'b0, 1'b1, 4, "R4");
      @(negedge clk); point("R4 low after absent guard", qual_det, 1'b0);
      // R3: short bursts of exactly P ticks rejected
      ticks(1'b1, 1'b1, 3, "R3");
      ticks(1'b0, 1'b1, 1, "R3");
      ticks(1'b1, 1'b1, 3, "R3");
      ticks(1'b0, 1'b1, 1, "R3");
      @(negedge clk); point("R3 short bursts ignored", qual_det, 1'b0);
      // asymmetric values: P=1, A=4
      present_ms = 8'd1; absent_ms = 8'd4;
      ticks(1'b1, 1'b1, 2, "R2");
      ticks(1'b0, 1'b1, 4, "R5");
      ticks(1'b1, 1'b1, 1, "R5");
      ticks(1'b0, 1'b1, 5, "R4");
      // R7: enable off while raw high, and on an expiring tick
      ticks(1'b1, 1'b1, 1, "R7");
      cyc(1'b1, 1'b0, 1'b1, "R7");
      ticks(1'b1, 1'b0, 4, "R7");
      @(negedge clk); point("R7 forced low", qual_det, 1'b0);
      ticks(1'b1, 1'b1, 2, "R7");
      cyc(1'b1, 1'b0, 1'b0, "R7");
      ticks(1'b1, 1'b1, 1, "R7");
      ticks(1'b1, 1'b1, 1, "R7");
      // R6: zero guard times follow raw at next tick
      present_ms = 8'd0; absent_ms = 8'd0;
      ticks(1'b0, 1'b1, 1, "R6");
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, "R6");
      cyc(1'b1, 1'b1, 1'b1, "R6");
      cyc(1'b0, 1'b1, 1'b0, "R6");
      cyc(1'b0, 1'b1, 1'b1, "R6");
      cyc(1'b1, 1'b1, 1'b1, "R6");
      cyc(1'b1, 1'b1, 1'b0, "R6");
      cyc(1'b1, 1'b1, 1'b0, "R6");
      @(negedge clk); point("R6 follows raw", qual_det, 1'b1);
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule